// File: doc/BRIEF.md
# Coupling-Fault Injecting RAM

This block is a single-port, register-based RAM that can be told to misbehave in a controlled way. It exists to exercise memory self-test logic. A self-test engine drives it like any small on-chip memory. Through a set of plain configuration pins, one two-cell coupling fault is switched in between a victim bit and an aggressor bit. When the aggressor holds, or is accessed with, a chosen value, the victim bit is corrupted, overridden or read wrongly. Which of these happens depends on the selected fault class.

The aggressor can be named directly by word address and bit. It can also be derived from the victim as a physical neighbour, given the number of words that share one physical row. Row neighbours sit one bit column to either side inside the same word. Column neighbours sit one row above or below, which is `WORDS_PER_ROW` addresses away. A neighbour that would fall outside the array disables the fault.

Accesses arrive on a valid/ready request channel. A request is accepted in any cycle where `req_valid` and `req_ready` are both high. Reads return data on a valid/ready response channel. `req_ready` is low only while a read response is held and `rsp_ready` is low. Writes produce no response. Read data and fault effects are computed from the array contents before the accepting edge. Any change to the array, including a fault-driven change to the victim, takes effect at that same edge.

Top module: `cpl_fault_ram`

## Requirements
- R1: After reset every word reads 0x00, `rsp_valid` is 0 and `req_ready` is 1.
- R2: With fault code 0, a read accepted at edge N shows `rsp_valid`=1 and the last written word on `rsp_rdata` after edge N. A write changes no response.
- R3: While `rsp_valid`=1 and `rsp_ready`=0, `rsp_rdata` stays stable, `rsp_valid` stays 1 and `req_ready` is 0. The response is released at the first edge with `rsp_ready`=1.
- R4: Code 1 (state coupling): at every edge where the aggressor bit after that edge's write equals `agg_cond`, the victim bit is set to `vic_force`, overriding any write to it. The victim is not restored when the aggressor changes.
- R5: Code 2 (disturb coupling): an accepted access to the aggressor word inverts the victim bit at the same edge. For a write, the written aggressor bit must equal `agg_cond`; for a read, the stored aggressor bit must.
- R6: Code 3 (transition coupling): while the stored aggressor bit equals `agg_cond`, a write that would move the victim from the inverse of `vic_force` to `vic_force` leaves the victim unchanged. Other bits of the word and the opposite transition are written normally.
- R7: Code 4 (incorrect-read coupling): while the stored aggressor bit equals `agg_cond`, a read of the victim word returns the victim bit inverted and leaves the array unchanged.
- R8: Code 5 (read-destructive coupling): while the stored aggressor bit equals `agg_cond`, a read of the victim word inverts the stored victim bit and returns the inverted value.
- R9: Code 6 (deceptive read-destructive coupling): while the stored aggressor bit equals `agg_cond`, a read of the victim word returns the correct value and inverts the stored victim bit.
- R10: With `agg_auto`=1, the aggressor is chosen by `nbr_dir`: 0 selects address−`WORDS_PER_ROW` at the same bit, 1 selects address+`WORDS_PER_ROW`, 2 selects bit+1 of the same word, and 3 selects bit−1. The explicit aggressor pins are then ignored.
- R11: Fault codes 0 and 7 have no effect. A neighbour outside the array, an aggressor equal to the victim, or a victim bit beyond the word width also disables the fault.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | DATA_W | Read response data |
| flt_kind | input | 3 | Fault class code (0 none, 1–6 as in R4–R9, 7 none) |
| vic_addr | input | ADDR_W | Victim word address |
| vic_bit | input | BIT_W | Victim bit position |
| agg_auto | input | 1 | 1 = aggressor from neighbour select |
| agg_addr | input | ADDR_W | Explicit aggressor word address |
| agg_bit | input | BIT_W | Explicit aggressor bit position |
| nbr_dir | input | 2 | Neighbour direction (R10 encoding) |
| agg_cond | input | 1 | Aggressor value that triggers the fault |
| vic_force | input | 1 | Forced victim value / blocked transition target |

## Verification
The assertions check properties that hold on every cycle. A held response must stay stable and hold off new requests. An accepted read must be answered. An active state fault must have set the victim by the next cycle. The fault logic must stay silent for codes 0 and 7 and for a disarmed fault. An incorrect-read fault must never write the array, and a deceptive fault must never alter read data. The aggressor resolver must never pick the victim cell itself. The actual data effect of each fault class, the neighbour direction encoding and the array-edge cases depend on sequences of writes and reads. Only the bench's scenarios show these, by comparing read data with values worked out from the requirements.

// File: rtl/cplf_pkg.sv
package cplf_pkg;

  typedef enum logic [2:0] {
    CPL_NONE       = 3'd0,
    CPL_STATE      = 3'd1,
    CPL_DISTURB    = 3'd2,
    CPL_TRANSITION = 3'd3,
    CPL_BADREAD    = 3'd4,
    CPL_DESTRUCT   = 3'd5,
    CPL_DECEPTIVE  = 3'd6,
    CPL_RSVD       = 3'd7
  } cpl_kind_e;

  typedef enum logic [1:0] {
    NBR_UP    = 2'd0,
    NBR_DOWN  = 2'd1,
    NBR_RIGHT = 2'd2,
    NBR_LEFT  = 2'd3
  } nbr_dir_e;

endpackage

// File: rtl/cplf_locate.sv
module cplf_locate
  import cplf_pkg::*;
#(
  parameter int ADDR_W        = 4,
  parameter int DATA_W        = 8,
  parameter int WORDS_PER_ROW = 4,
  parameter int BIT_W         = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] vic_addr,
  input  logic [BIT_W-1:0]  vic_bit,
  input  logic              agg_auto,
  input  logic [ADDR_W-1:0] man_addr,
  input  logic [BIT_W-1:0]  man_bit,
  input  logic [1:0]        nbr_dir,
  output logic [ADDR_W-1:0] agg_addr,
  output logic [BIT_W-1:0]  agg_bit,
  output logic              agg_ok
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] ROW_STEP = ADDR_W'(WORDS_PER_ROW);

  logic in_range;
  logic vic_ok;
  logic same_cell;
  nbr_dir_e dir;

  assign dir = nbr_dir_e'(nbr_dir);

  always_comb begin
    agg_addr = man_addr;
    agg_bit  = man_bit;
    in_range = int'(man_bit) < DATA_W;
    if (agg_auto) begin
      agg_addr = vic_addr;
      agg_bit  = vic_bit;
      case (dir)
        NBR_UP: begin
          agg_addr = vic_addr - ROW_STEP;
          in_range = int'(vic_addr) >= WORDS_PER_ROW;
        end
        NBR_DOWN: begin
          agg_addr = vic_addr + ROW_STEP;
          in_range = int'(vic_addr) + WORDS_PER_ROW < DEPTH;
        end
        NBR_RIGHT: begin
          agg_bit  = vic_bit + BIT_W'(1);
          in_range = int'(vic_bit) + 1 < DATA_W;
        end
        default: begin
          agg_bit  = vic_bit - BIT_W'(1);
          in_range = int'(vic_bit) > 0;
        end
      endcase
    end
  end

  assign vic_ok    = int'(vic_bit) < DATA_W;
  assign same_cell = (agg_addr == vic_addr) && (agg_bit == vic_bit);
  assign agg_ok    = in_range && vic_ok && !same_cell;

  // R10/R11: the chosen aggressor is never the victim cell itself
  a_r10_not_self: assert property (@(posedge clk) disable iff (!rst_n)
    agg_ok |-> !((agg_addr == vic_addr) && (agg_bit == vic_bit)));

  // R11: an upward neighbour of a top-row victim never arms the fault
  a_r11_top_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (agg_auto && nbr_dir == 2'd0 && int'(vic_addr) < WORDS_PER_ROW) |-> !agg_ok);

endmodule

// File: rtl/cplf_effect.sv
module cplf_effect
  import cplf_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int BIT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        kind_code,
  input  logic              armed,
  input  logic              op_go,
  input  logic              op_wr,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [DATA_W-1:0] op_wdata,
  input  logic [DATA_W-1:0] op_word,
  input  logic [ADDR_W-1:0] vic_addr,
  input  logic [BIT_W-1:0]  vic_bit,
  input  logic [DATA_W-1:0] vic_word,
  input  logic [ADDR_W-1:0] agg_addr,
  input  logic [BIT_W-1:0]  agg_bit,
  input  logic [DATA_W-1:0] agg_word,
  input  logic              agg_cond,
  input  logic              vic_force,
  output logic              fix_en,
  output logic              fix_val,
  output logic [DATA_W-1:0] rd_out
);
  cpl_kind_e kind;
  logic acc_vic, acc_agg;
  logic vic_old, agg_old;
  logic agg_seen, vic_after, agg_hit, vic_rd;

  assign kind = cpl_kind_e'(kind_code);

  always_comb begin
    acc_vic   = op_go && (op_addr == vic_addr);
    acc_agg   = op_go && (op_addr == agg_addr);
    vic_old   = vic_word[vic_bit];
    agg_old   = agg_word[agg_bit];
    agg_seen  = (acc_agg && op_wr) ? op_wdata[agg_bit] : agg_old;
    vic_after = (acc_vic && op_wr) ? op_wdata[vic_bit] : vic_old;
    agg_hit   = (agg_old == agg_cond);
    vic_rd    = acc_vic && !op_wr && agg_hit;
    fix_en    = 1'b0;
    fix_val   = vic_after;
    rd_out    = op_word;
    if (armed) begin
      case (kind)
        CPL_STATE: begin
          if (agg_seen == agg_cond) begin
            fix_en  = 1'b1;
            fix_val = vic_force;
          end
        end
        CPL_DISTURB: begin
          if (acc_agg && agg_seen == agg_cond) begin
            fix_en  = 1'b1;
            fix_val = ~vic_after;
          end
        end
        CPL_TRANSITION: begin
          if (acc_vic && op_wr && agg_hit && vic_old != vic_force &&
              op_wdata[vic_bit] == vic_force) begin
            fix_en  = 1'b1;
            fix_val = vic_old;
          end
        end
        CPL_BADREAD: begin
          if (vic_rd) rd_out[vic_bit] = ~vic_old;
        end
        CPL_DESTRUCT: begin
          if (vic_rd) begin
            fix_en          = 1'b1;
            fix_val         = ~vic_old;
            rd_out[vic_bit] = ~vic_old;
          end
        end
        CPL_DECEPTIVE: begin
          if (vic_rd) begin
            fix_en  = 1'b1;
            fix_val = ~vic_old;
          end
        end
        default: ;
      endcase
    end
  end

  // R11: codes 0 and 7, or a disarmed fault, leave array and read data alone
  a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed || kind_code == 3'd0 || kind_code == 3'd7) |-> (!fix_en && rd_out == op_word));

  // R7: incorrect-read coupling never writes the array
  a_r7_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && kind_code == 3'd4) |-> !fix_en);

  // R9: deceptive read-destructive coupling always returns the stored data
  a_r9_truthful: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && kind_code == 3'd6) |-> (rd_out == op_word));

  // R6: a blocked transition only ever holds the victim off the forced value
  a_r6_blocks_target: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && kind_code == 3'd3 && fix_en) |-> (fix_val != vic_force));

endmodule

// File: rtl/cplf_store.sv
module cplf_store #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int BIT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              fix_en,
  input  logic [ADDR_W-1:0] fix_addr,
  input  logic [BIT_W-1:0]  fix_bit,
  input  logic              fix_val,
  input  logic [ADDR_W-1:0] rd_addr_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  input  logic [ADDR_W-1:0] rd_addr_c,
  output logic [DATA_W-1:0] rd_word_a,
  output logic [DATA_W-1:0] rd_word_b,
  output logic [DATA_W-1:0] rd_word_c
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
    end else begin
      for (int w = 0; w < DEPTH; w++) begin
        if (wr_en && wr_addr == ADDR_W'(w)) mem[w] <= wr_data;
        if (fix_en && fix_addr == ADDR_W'(w)) mem[w][fix_bit] <= fix_val;
      end
    end
  end

  assign rd_word_a = mem[rd_addr_a];
  assign rd_word_b = mem[rd_addr_b];
  assign rd_word_c = mem[rd_addr_c];

endmodule

// File: rtl/cplf_rsp.sv
module cplf_rsp #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic              can_take,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata
);
  assign can_take = !rsp_valid || rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (load) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= load_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R3: a stalled response holds its data and stays valid
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

endmodule

// File: rtl/cpl_fault_ram.sv
module cpl_fault_ram
  import cplf_pkg::*;
#(
  parameter int ADDR_W        = 4,
  parameter int DATA_W        = 8,
  parameter int WORDS_PER_ROW = 4,
  parameter int BIT_W         = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [2:0]        flt_kind,
  input  logic [ADDR_W-1:0] vic_addr,
  input  logic [BIT_W-1:0]  vic_bit,
  input  logic              agg_auto,
  input  logic [ADDR_W-1:0] agg_addr,
  input  logic [BIT_W-1:0]  agg_bit,
  input  logic [1:0]        nbr_dir,
  input  logic              agg_cond,
  input  logic              vic_force
);
  logic              op_go;
  logic              rd_load;
  logic [ADDR_W-1:0] sel_addr;
  logic [BIT_W-1:0]  sel_bit;
  logic              sel_ok;
  logic [DATA_W-1:0] op_word, vic_word, agg_word, rd_out;
  logic              fix_en, fix_val;

  assign op_go   = req_valid && req_ready;
  assign rd_load = op_go && !req_write;

  cplf_locate #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS_PER_ROW(WORDS_PER_ROW), .BIT_W(BIT_W)
  ) u_locate (
    .clk(clk), .rst_n(rst_n),
    .vic_addr(vic_addr), .vic_bit(vic_bit),
    .agg_auto(agg_auto), .man_addr(agg_addr), .man_bit(agg_bit), .nbr_dir(nbr_dir),
    .agg_addr(sel_addr), .agg_bit(sel_bit), .agg_ok(sel_ok)
  );

  cplf_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BIT_W(BIT_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(op_go && req_write), .wr_addr(req_addr), .wr_data(req_wdata),
    .fix_en(fix_en), .fix_addr(vic_addr), .fix_bit(vic_bit), .fix_val(fix_val),
    .rd_addr_a(req_addr), .rd_addr_b(vic_addr), .rd_addr_c(sel_addr),
    .rd_word_a(op_word), .rd_word_b(vic_word), .rd_word_c(agg_word)
  );

  cplf_effect #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BIT_W(BIT_W)) u_effect (
    .clk(clk), .rst_n(rst_n),
    .kind_code(flt_kind), .armed(sel_ok),
    .op_go(op_go), .op_wr(req_write), .op_addr(req_addr),
    .op_wdata(req_wdata), .op_word(op_word),
    .vic_addr(vic_addr), .vic_bit(vic_bit), .vic_word(vic_word),
    .agg_addr(sel_addr), .agg_bit(sel_bit), .agg_word(agg_word),
    .agg_cond(agg_cond), .vic_force(vic_force),
    .fix_en(fix_en), .fix_val(fix_val), .rd_out(rd_out)
  );

  cplf_rsp #(.DATA_W(DATA_W)) u_rsp (
    .clk(clk), .rst_n(rst_n),
    .load(rd_load), .load_data(rd_out), .can_take(req_ready),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata)
  );

  // R2: every accepted read is answered after the accepting edge
  a_r2_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
    rd_load |=> rsp_valid);

  // R3: no request is taken while a response is stalled
  a_r3_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R4: with the aggressor at its trigger value and no write, the victim is forced by the next cycle
  a_r4_state_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_kind == 3'd1 && sel_ok && agg_word[sel_bit] == agg_cond && !(op_go && req_write))
    |=> (!$stable(vic_addr) || !$stable(vic_bit) || vic_word[vic_bit] == $past(vic_force)));

endmodule

// File: tb/cpl_fault_ram_bench.sv
module cpl_fault_ram_bench;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int WPR    = 4;
  localparam int BIT_W  = 3;
  localparam int NVEC   = 11;

  // {write, addr[3:0], wdata[7:0], expected[7:0]}
  localparam logic [20:0] VEC [NVEC] = '{
    21'h10A500, 21'h1F3C00, 21'h17FF00, 21'h0000A5, 21'h0F003C, 21'h0700FF,
    21'h100000, 21'h000000, 21'h0C0000, 21'h1C8100, 21'h0C0081
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic rsp_ready = 1'b1;
  logic [DATA_W-1:0] rsp_rdata;
  logic [2:0] flt_kind = 3'd0;
  logic [ADDR_W-1:0] vic_addr = '0, agg_addr = '0;
  logic [BIT_W-1:0] vic_bit = '0, agg_bit = '0;
  logic agg_auto = 1'b0, agg_cond = 1'b0, vic_force = 1'b0;
  logic [1:0] nbr_dir = 2'd0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cpl_fault_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS_PER_ROW(WPR)) u_cpl_fault_ram (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .flt_kind(flt_kind), .vic_addr(vic_addr), .vic_bit(vic_bit),
    .agg_auto(agg_auto), .agg_addr(agg_addr), .agg_bit(agg_bit),
    .nbr_dir(nbr_dir), .agg_cond(agg_cond), .vic_force(vic_force)
  );

  task automatic chk(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk);
    #1;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic do_read(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk);
    #1;
    d = rsp_valid ? rsp_rdata : 'x;
    req_valid = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] exp);
    logic [DATA_W-1:0] d;
    do_read(a, d);
    chk(tag, d, exp);
  endtask

  task automatic set_fault(input logic [2:0] k, input logic [ADDR_W-1:0] va, input logic [BIT_W-1:0] vb,
                           input logic au, input logic [ADDR_W-1:0] aa, input logic [BIT_W-1:0] ab,
                           input logic [1:0] dir, input logic cnd, input logic frc);
    @(negedge clk);
    flt_kind = k; vic_addr = va; vic_bit = vb; agg_auto = au; agg_addr = aa; agg_bit = ab;
    nbr_dir = dir; agg_cond = cnd; vic_force = frc;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    chk("R1 req_ready", {7'd0, req_ready}, 8'h01);
    chk("R1 rsp_valid", {7'd0, rsp_valid}, 8'h00);
    rd_chk("R1 word0", 4'd0, 8'h00);
    rd_chk("R1 word15", 4'd15, 8'h00);

    // R2: fault-free vector walk
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][20]) do_write(VEC[i][19:16], VEC[i][15:8]);
      else rd_chk("R2 vector read", VEC[i][19:16], VEC[i][7:0]);
    end

    // R3: back-pressure holds the response and blocks requests
    begin
      logic [DATA_W-1:0] first;
      @(negedge clk);
      rsp_ready = 1'b0; req_valid = 1'b1; req_write = 1'b0; req_addr = 4'd12;
      @(posedge clk); #1;
      req_valid = 1'b0;
      first = rsp_rdata;
      chk("R3 valid raised", {7'd0, rsp_valid}, 8'h01);
      chk("R3 ready low", {7'd0, req_ready}, 8'h00);
      @(posedge clk); #1;
      chk("R3 held valid", {7'd0, rsp_valid}, 8'h01);
      chk("R3 held data", rsp_rdata, first);
      chk("R3 data value", rsp_rdata, 8'h81);
      @(negedge clk); rsp_ready = 1'b1;
      @(posedge clk); #1;
      chk("R3 released", {7'd0, rsp_valid}, 8'h00);
    end

    // R4: state coupling, victim w2 b3, aggressor w5 b0, trigger 1, force 1
    set_fault(3'd0, 4'd2, 3'd3, 1'b0, 4'd5, 3'd0, 2'd0, 1'b1, 1'b1);
    do_write(4'd2, 8'h00); do_write(4'd5, 8'h00);
    set_fault(3'd1, 4'd2, 3'd3, 1'b0, 4'd5, 3'd0, 2'd0, 1'b1, 1'b1);
    rd_chk("R4 idle aggressor", 4'd2, 8'h00);
    do_write(4'd5, 8'h01);
    rd_chk("R4 forced", 4'd2, 8'h08);
    do_write(4'd2, 8'h00);
    rd_chk("R4 write overridden", 4'd2, 8'h08);
    do_write(4'd5, 8'h00);
    rd_chk("R4 not restored", 4'd2, 8'h08);
    do_write(4'd2, 8'h00);
    rd_chk("R4 released write", 4'd2, 8'h00);

    // R5: disturb coupling, victim w3 b1, aggressor w7 b6, trigger 1
    set_fault(3'd0, 4'd3, 3'd1, 1'b0, 4'd7, 3'd6, 2'd0, 1'b1, 1'b0);
    do_write(4'd3, 8'h00); do_write(4'd7, 8'h00);
    set_fault(3'd2, 4'd3, 3'd1, 1'b0, 4'd7, 3'd6, 2'd0, 1'b1, 1'b0);
    do_write(4'd7, 8'h40);
    rd_chk("R5 write disturbs", 4'd3, 8'h02);
    rd_chk("R5 aggressor read", 4'd7, 8'h40);
    rd_chk("R5 read disturbs", 4'd3, 8'h00);
    do_write(4'd7, 8'h00);
    rd_chk("R5 other value quiet", 4'd3, 8'h00);

    // R6: transition coupling, victim w1 b0, aggressor w9 b2, trigger 0, blocked rise
    set_fault(3'd0, 4'd1, 3'd0, 1'b0, 4'd9, 3'd2, 2'd0, 1'b0, 1'b1);
    do_write(4'd1, 8'h00); do_write(4'd9, 8'h00);
    set_fault(3'd3, 4'd1, 3'd0, 1'b0, 4'd9, 3'd2, 2'd0, 1'b0, 1'b1);
    do_write(4'd1, 8'hFF);
    rd_chk("R6 rise blocked", 4'd1, 8'hFE);
    do_write(4'd9, 8'h04);
    do_write(4'd1, 8'hFF);
    rd_chk("R6 rise allowed", 4'd1, 8'hFF);
    do_write(4'd9, 8'h00);
    do_write(4'd1, 8'h00);
    rd_chk("R6 fall allowed", 4'd1, 8'h00);

    // R7: incorrect-read coupling, victim w4 b7, aggressor w6 b3, trigger 1
    set_fault(3'd0, 4'd4, 3'd7, 1'b0, 4'd6, 3'd3, 2'd0, 1'b1, 1'b0);
    do_write(4'd4, 8'h0F); do_write(4'd6, 8'h08);
    set_fault(3'd4, 4'd4, 3'd7, 1'b0, 4'd6, 3'd3, 2'd0, 1'b1, 1'b0);
    rd_chk("R7 wrong read", 4'd4, 8'h8F);
    rd_chk("R7 wrong read again", 4'd4, 8'h8F);
    set_fault(3'd0, 4'd4, 3'd7, 1'b0, 4'd6, 3'd3, 2'd0, 1'b1, 1'b0);
    rd_chk("R7 stored kept", 4'd4, 8'h0F);

    // R8: read-destructive coupling, victim w8 b2, aggressor w10 b0, trigger 0
    set_fault(3'd0, 4'd8, 3'd2, 1'b0, 4'd10, 3'd0, 2'd0, 1'b0, 1'b0);
    do_write(4'd8, 8'h04); do_write(4'd10, 8'h00);
    set_fault(3'd5, 4'd8, 3'd2, 1'b0, 4'd10, 3'd0, 2'd0, 1'b0, 1'b0);
    rd_chk("R8 flipped read", 4'd8, 8'h00);
    rd_chk("R8 flips back", 4'd8, 8'h04);
    set_fault(3'd0, 4'd8, 3'd2, 1'b0, 4'd10, 3'd0, 2'd0, 1'b0, 1'b0);
    rd_chk("R8 stored after two", 4'd8, 8'h04);

    // R9: deceptive read-destructive coupling, same cells
    set_fault(3'd6, 4'd8, 3'd2, 1'b0, 4'd10, 3'd0, 2'd0, 1'b0, 1'b0);
    rd_chk("R9 correct read", 4'd8, 8'h04);
    set_fault(3'd0, 4'd8, 3'd2, 1'b0, 4'd10, 3'd0, 2'd0, 1'b0, 1'b0);
    rd_chk("R9 stored flipped", 4'd8, 8'h00);

    // R10: neighbour selection with state coupling, victim w5 b4, trigger 1, force 1
    for (int d = 0; d < 4; d++) begin
      logic [ADDR_W-1:0] ga;
      logic [DATA_W-1:0] gw, exp;
      case (d)
        0: begin ga = 4'd1; gw = 8'h10; exp = 8'h10; end
        1: begin ga = 4'd9; gw = 8'h10; exp = 8'h10; end
        2: begin ga = 4'd5; gw = 8'h20; exp = 8'h30; end
        default: begin ga = 4'd5; gw = 8'h08; exp = 8'h18; end
      endcase
      set_fault(3'd0, 4'd5, 3'd4, 1'b1, 4'd0, 3'd0, 2'(d), 1'b1, 1'b1);
      do_write(4'd1, 8'h00); do_write(4'd9, 8'h00); do_write(4'd5, 8'h00); do_write(4'd0, 8'hFF);
      set_fault(3'd1, 4'd5, 3'd4, 1'b1, 4'd0, 3'd0, 2'(d), 1'b1, 1'b1);
      rd_chk("R10 explicit pins ignored", 4'd5, 8'h00);
      do_write(ga, gw);
      rd_chk("R10 neighbour drives victim", 4'd5, exp);
    end

    // R11: out-of-array neighbours and reserved code disable the fault
    set_fault(3'd0, 4'd1, 3'd4, 1'b1, 4'd0, 3'd0, 2'd0, 1'b0, 1'b1);
    do_write(4'd1, 8'h00); do_write(4'd13, 8'h00); do_write(4'd2, 8'h00);
    set_fault(3'd1, 4'd1, 3'd4, 1'b1, 4'd0, 3'd0, 2'd0, 1'b0, 1'b1);
    rd_chk("R11 no row above", 4'd1, 8'h00);
    set_fault(3'd1, 4'd2, 3'd7, 1'b1, 4'd0, 3'd0, 2'd2, 1'b0, 1'b1);
    rd_chk("R11 no bit to the right", 4'd2, 8'h00);
    set_fault(3'd7, 4'd1, 3'd4, 1'b0, 4'd13, 3'd0, 2'd0, 1'b0, 1'b1);
    rd_chk("R11 reserved code", 4'd1, 8'h00);
    set_fault(3'd1, 4'd1, 3'd4, 1'b0, 4'd1, 3'd4, 2'd0, 1'b0, 1'b1);
    rd_chk("R11 self aggressor", 4'd1, 8'h00);

    finish_run();
  end
endmodule